// File: doc/BRIEF.md
# Converter result and calibration register bank

This block is the register file that sits behind a byte-wide serial slave port on a sensor converter. The bus engine in front of it is reduced to four strobes: transaction start, transaction stop, byte written by the host and byte requested by the host. The first byte written after a start loads an address pointer. Every later byte, read or written, uses the pointer and then moves it up by one, so a multi-byte register can be read or written in one transaction.

The bank holds a read-only conversion result, a read/write offset coefficient and a read/write gain coefficient. Each is 16 bits wide and is split into a high byte at the lower address and a low byte at the next address. The converter delivers new results on a valid strobe. A result is stored at once unless the host has a read open. In that case the result is dropped and is not held for later, so the two result bytes always belong to the same conversion.

Top module: `sensor_regbank`

## Requirements
- R1: After reset the result reads 0x0000, the offset reads 0x8000 (parameter OFFSET_INIT), the gain reads the parameter GAIN_INIT (0x9C40 by default), the pointer is 0x00 and `read_open` is 0.
- R2: Address map: result high byte 0x01 and low byte 0x02, offset high 0x05 and low 0x06, gain high 0x09 and low 0x0A. The high byte is always at the lower address.
- R3: Only the upper 12 bits of the result are stored. Bits 3:0 of the result low byte always read as 0.
- R4: The first `wr_en` byte after `bus_start` loads the pointer from `wr_data`. Each later `wr_en` byte writes the register at the pointer and then increments the pointer.
- R5: A `rd_en` pulse puts the byte at the pointer on `rd_data` in the next cycle and increments the pointer. `rd_data` holds its value until the next `rd_en`.
- R6: After a byte access at 0x0A or at any higher pointer value, the pointer wraps to 0x00.
- R7: Writes to 0x01, 0x02 and to unimplemented addresses have no effect. Unimplemented addresses read as 0x00.
- R8: A `res_valid` pulse while no read is open stores `res_data` as the new result, visible from the next cycle.
- R9: `read_open` rises on the first `rd_en` and falls on `bus_stop`. A `res_valid` in the same cycle as `rd_en`, while `read_open` is 1, or in the same cycle as `bus_stop`, is discarded and is not applied after the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Transaction start (or repeated start) seen on the bus |
| bus_stop | input | 1 | Transaction stop seen on the bus |
| wr_en | input | 1 | Host has written one byte |
| wr_data | input | 8 | Byte written by the host |
| rd_en | input | 1 | Host requests one byte |
| rd_data | output | 8 | Byte returned, valid the cycle after `rd_en` |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | 16 | Converter result, left-aligned |
| read_open | output | 1 | A host read transaction is in progress |

## Verification
On every cycle the assertions check that the stored result cannot change while a read is open or in a read cycle, that a stop always closes the read, that a read byte always opens it, that the pointer wraps after the top address, that writes aimed at the result leave it unchanged, and that the result low nibble returns zero. Only the bench's scenarios can show that the byte values travel correctly through the address map and through a multi-byte access. They also show that a result arriving mid-read is lost for good, not held back and applied after the stop. These scenarios include strobes that coincide with a read byte and with the stop.

// File: rtl/sensor_regbank.sv
module sensor_regbank #(
  parameter logic [15:0] GAIN_INIT   = 16'h9C40,
  parameter logic [15:0] OFFSET_INIT = 16'h8000,
  parameter int          RES_BITS    = 12,
  parameter logic [7:0]  TOP_ADDR    = 8'h0A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_start,
  input  logic        bus_stop,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic        res_valid,
  input  logic [15:0] res_data,
  output logic        read_open
);

  localparam int         PAD      = 16 - RES_BITS;
  localparam logic [7:0] A_RES_H  = 8'h01;
  localparam logic [7:0] A_RES_L  = 8'h02;
  localparam logic [7:0] A_OFF_H  = 8'h05;
  localparam logic [7:0] A_OFF_L  = 8'h06;
  localparam logic [7:0] A_GAIN_H = 8'h09;
  localparam logic [7:0] A_GAIN_L = 8'h0A;

  logic [RES_BITS-1:0] res_q;
  logic [15:0]         off_q, gain_q;
  logic [7:0]          ptr, ptr_nxt, rd_mux;
  logic                want_addr;
  logic                data_wr, take_res;
  logic [15:0]         res_word;

  assign res_word = {res_q, {PAD{1'b0}}};
  assign ptr_nxt  = (ptr >= TOP_ADDR) ? 8'h00 : ptr + 8'h01;
  assign data_wr  = wr_en && !want_addr;
  assign take_res = res_valid && !read_open && !rd_en && !bus_stop;

  always_comb begin
    case (ptr)
      A_RES_H:  rd_mux = res_word[15:8];
      A_RES_L:  rd_mux = res_word[7:0];
      A_OFF_H:  rd_mux = off_q[15:8];
      A_OFF_L:  rd_mux = off_q[7:0];
      A_GAIN_H: rd_mux = gain_q[15:8];
      A_GAIN_L: rd_mux = gain_q[7:0];
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= 8'h00;
      want_addr <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      if (rd_en) begin
        rd_data <= rd_mux;
        ptr     <= ptr_nxt;
      end else if (wr_en && want_addr) begin
        ptr <= wr_data;
      end else if (data_wr) begin
        ptr <= ptr_nxt;
      end
      if (bus_start)            want_addr <= 1'b1;
      else if (bus_stop)        want_addr <= 1'b0;
      else if (wr_en || rd_en)  want_addr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        read_open <= 1'b0;
    else if (bus_stop) read_open <= 1'b0;
    else if (rd_en)    read_open <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= OFFSET_INIT;
      gain_q <= GAIN_INIT;
    end else if (data_wr) begin
      case (ptr)
        A_OFF_H:  off_q[15:8]  <= wr_data;
        A_OFF_L:  off_q[7:0]   <= wr_data;
        A_GAIN_H: gain_q[15:8] <= wr_data;
        A_GAIN_L: gain_q[7:0]  <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (take_res) res_q <= res_data[15:PAD];
  end

  AST_LOCKED_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (read_open || rd_en) |=> $stable(res_q)) else $error("locked result changed"); // R9
  AST_STOP_CLOSES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !read_open) else $error("stop did not close read"); // R9
  AST_READ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bus_stop) |=> read_open) else $error("read byte did not open read"); // R9
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ptr >= TOP_ADDR) |=> (ptr == 8'h00)) else $error("pointer did not wrap"); // R6
  AST_RESULT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !res_valid && (ptr == A_RES_H || ptr == A_RES_L)) |=> $stable(res_q))
    else $error("write reached result"); // R7
  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ptr == A_RES_L) |=> (rd_data[PAD-1:0] == '0)) else $error("low bits nonzero"); // R3

endmodule

// File: tb/sensor_regbank_bench.sv
module sensor_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] GAIN_DEF = 16'h9C40;

  logic clk = 0, rst_n = 0;
  logic bus_start = 0, bus_stop = 0, wr_en = 0, rd_en = 0, res_valid = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] res_data = 0;
  logic [7:0] rd_data;
  logic read_open;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  sensor_regbank u_sensor_regbank (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .res_valid(res_valid), .res_data(res_data), .read_open(read_open));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_res, m_off, m_gain, m_ptr, m_rd;
  bit m_addr, m_open;

  function automatic int m_byte(int a);
    case (a)
      1: return (m_res >> 8) & 255;
      2: return m_res & 255;
      5: return (m_off >> 8) & 255;
      6: return m_off & 255;
      9: return (m_gain >> 8) & 255;
      10: return m_gain & 255;
      default: return 0;
    endcase
  endfunction

  function automatic int m_next(int a);
    return (a >= 10) ? 0 : a + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = 0; m_off = 16'h8000; m_gain = GAIN_DEF; m_ptr = 0; m_rd = 0;
      m_addr = 0; m_open = 0;
    end else begin
      bit upd;
      upd = res_valid && !m_open && !rd_en && !bus_stop;
      if (rd_en) begin
        m_rd = m_byte(m_ptr); m_ptr = m_next(m_ptr); m_open = 1;
      end
      if (wr_en) begin
        if (m_addr) begin
          m_ptr = wr_data; m_addr = 0;
        end else begin
          case (m_ptr)
            5: m_off = (m_off & 255) | (int'(wr_data) << 8);
            6: m_off = (m_off & 16'hFF00) | wr_data;
            9: m_gain = (m_gain & 255) | (int'(wr_data) << 8);
            10: m_gain = (m_gain & 16'hFF00) | wr_data;
            default: ;
          endcase
          m_ptr = m_next(m_ptr);
        end
      end
      if (rd_en) m_addr = 0;
      if (bus_stop) begin m_open = 0; m_addr = 0; end
      if (bus_start) m_addr = 1;
      if (upd) m_res = res_data & 16'hFFF0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R5 byte path, R9 flag)
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 rd_data vs model", rd_data, m_rd);
    chk("R9 read_open vs model", read_open, m_open);
  end

  task automatic idle();
    @(posedge clk); #1;
    bus_start = 0; bus_stop = 0; wr_en = 0; rd_en = 0; res_valid = 0;
  endtask

  task automatic start(); bus_start = 1; idle(); endtask
  task automatic stop();  bus_stop = 1;  idle(); endtask
  task automatic wbyte(int b); wr_en = 1; wr_data = 8'(b); idle(); endtask

  task automatic rbyte(string tag, int exp);
    rd_en = 1; idle();
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse_result(int v);
    res_valid = 1; res_data = 16'(v); idle();
  endtask

  task automatic read2(string tag, int addr, int exp);
    start(); wbyte(addr);
    rbyte(tag, (exp >> 8) & 255);
    rbyte(tag, exp & 255);
    stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 read_open at reset", read_open, 0);
    chk("R1 rd_data at reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 / R2 reset values through the map
    read2("R1 result reset", 8'h01, 16'h0000);
    read2("R1 offset reset", 8'h05, 16'h8000);
    read2("R2 gain reset", 8'h09, GAIN_DEF);
    // R8, R3: idle result commit, low nibble cleared
    pulse_result(16'hABCD);
    read2("R8 R3 result commit", 8'h01, 16'hABC0);
    // R4: write offset and read back
    start(); wbyte(8'h05); wbyte(8'h12); wbyte(8'h34); stop();
    read2("R4 offset write", 8'h05, 16'h1234);
    start(); wbyte(8'h09); wbyte(8'h55); wbyte(8'hAA); stop();
    read2("R2 gain write", 8'h09, 16'h55AA);
    // R7: read-only and unimplemented writes ignored
    start(); wbyte(8'h01); wbyte(8'hFF); wbyte(8'hFF); stop();
    read2("R7 result not writable", 8'h01, 16'hABC0);
    start(); wbyte(8'h03); wbyte(8'h77); stop();
    start(); wbyte(8'h03); rbyte("R7 unimplemented reads zero", 0); stop();
    // R6: wrap from 0x0A to 0x00 then 0x01
    start(); wbyte(8'h0A);
    rbyte("R6 top byte", 8'hAA);
    rbyte("R6 wrapped to 0x00", 0);
    rbyte("R6 then 0x01", 8'hAB);
    stop();
    start(); wbyte(8'hF0); rbyte("R6 above top", 0); rbyte("R6 wrap from above", 0); stop();
    // R9: result arriving mid-read is dropped
    start(); wbyte(8'h01);
    rbyte("R9 high byte", 8'hAB);
    pulse_result(16'h1234);
    rbyte("R9 low byte coherent", 8'hC0);
    stop();
    read2("R9 not applied after stop", 8'h01, 16'hABC0);
    // R9: strobe coincident with read byte
    start(); wbyte(8'h01);
    rd_en = 1; res_valid = 1; res_data = 16'h4444; idle();
    @(negedge clk); chk("R9 same-cycle read byte", rd_data, 8'hAB);
    stop();
    read2("R9 same-cycle strobe dropped", 8'h01, 16'hABC0);
    // R9: strobe coincident with stop
    start(); wbyte(8'h02); rbyte("R9 pre-stop read", 8'hC0);
    bus_stop = 1; res_valid = 1; res_data = 16'h5555; idle();
    read2("R9 stop-cycle strobe dropped", 8'h01, 16'hABC0);
    // R8: strobe after stop commits
    pulse_result(16'h7E9F);
    read2("R8 commit after stop", 8'h01, 16'h7E90);
    repeat (3) idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule